// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Bus Master

This block moves single bytes between a host and a serial EEPROM over an I2C bus at standard-mode rate. The host presents one command: a 7-bit device address, a read/write flag, a 16-bit memory location and a write byte. The block then runs the whole bus transaction on its own. It reports completion with a one-cycle done pulse, and it sets an error flag when the EEPROM fails to acknowledge.

Each transaction opens with the device address and a write direction bit, followed by the memory location, high byte first. A write then sends its data byte and stops. A read turns the bus around with a repeated START and the device address with the read bit set. It then clocks in one byte, refuses further data with a NACK and stops. After every byte the block sends, it checks the acknowledge slot. The block has no time limit on any phase. When a slave holds SCL low, the block waits as long as the hold lasts.

Both bus lines are open-drain. An output enable of 1 pulls the line low, and 0 releases it. The block also reads both lines back.

Top module: `eeprom_i2c_master`

## Requirements
- R1: In the cycle after reset, busy, done and ack_err are 0, and both scl_oe and sda_oe are 0 (lines released).
- R2: A write command (cmd_rd=0) produces START, then {cmd_dev,1'b0}, cmd_mem[15:8], cmd_mem[7:0] and cmd_wdata, each sent MSB first and each acknowledged, then STOP. done then pulses with ack_err=0, and both lines are released in the done cycle.
- R3: A read command (cmd_rd=1) produces START, {cmd_dev,1'b0}, cmd_mem[15:8], cmd_mem[7:0], a repeated START and {cmd_dev,1'b1}. It then reads 8 bits MSB first, leaves SDA released in the 9th clock (NACK) and ends with STOP. rdata holds the byte read when done pulses.
- R4: If SDA is high in the acknowledge clock of any byte the block sends, no further byte is sent. The block issues STOP and pulses done with ack_err=1. rdata keeps its previous value. ack_err stays set until the next command is accepted.
- R5: SDA changes only while SCL is low, except for START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high). A write has exactly one START and one STOP. A read adds exactly one repeated START.
- R6: With QDIV = CLK_HZ/(4*SCL_HZ), every SCL high pulse of an address, data or acknowledge bit lasts exactly 2*QDIV clock cycles when no slave holds the clock.
- R7: A command is accepted only when cmd_valid=1 and busy=0, and busy is 1 in the next cycle. cmd_valid while busy has no effect on the bus traffic, and no command is queued.
- R8: done is high for exactly one cycle per command, and busy is 0 in that cycle.
- R9: While the block releases SCL and the line stays low, the block keeps SCL released and does not advance. The transfer completes correctly after the line is freed.
- R10: An SCL hold of thousands of cycles produces no error and no abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when busy is 0 |
| cmd_dev | input | 7 | Device address |
| cmd_rd | input | 1 | 1 = read one byte, 0 = write one byte |
| cmd_mem | input | 16 | Memory location inside the EEPROM |
| cmd_wdata | input | 8 | Byte to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| ack_err | output | 1 | Last transaction lost an acknowledge |
| rdata | output | 8 | Byte from the last successful read |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |

## Verification
The properties assume three things about the bus. SCL reads high within one cycle of release unless a slave holds it on purpose. A low SCL seen while the block releases the line is therefore always such a hold. cmd_valid is assumed to be a clean level that the block samples only when idle. The bench slave model keeps to these rules. It changes SDA only on the clock edge after it sees SCL fall, and it holds SCL only in the gap after an acknowledge clock. It never touches the lines around START or STOP.

// File: rtl/eei2c_pkg.sv
package eei2c_pkg;

    typedef enum logic [1:0] {
        OP_START,
        OP_STOP,
        OP_WRITE,
        OP_READ
    } bitop_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_TX,
        SQ_RSTART,
        SQ_RX,
        SQ_NACK,
        SQ_STOP
    } seq_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } pins_s;

    typedef struct packed {
        logic [6:0]  dev;
        logic        rd;
        logic [15:0] mem;
        logic [7:0]  wdata;
    } xfer_s;

    // Line drive for one quarter of a bit slot.
    function automatic pins_s phase_pins(bitop_e op, logic [1:0] ph,
                                         logic wbit, logic scl_prev);
        pins_s p;
        p.scl_low = (ph == 2'd0) || (ph == 2'd3);
        p.sda_low = 1'b0;
        case (op)
            OP_START: begin
                p.sda_low = ph[1];
                p.scl_low = (ph == 2'd0) ? scl_prev : (ph == 2'd3);
            end
            OP_STOP: begin
                p.sda_low = !ph[1];
                p.scl_low = (ph == 2'd0);
            end
            OP_WRITE: p.sda_low = !wbit;
            default:  p.sda_low = 1'b0;
        endcase
        return p;
    endfunction

    function automatic logic [7:0] addr_byte(logic [6:0] dev, logic rd);
        return {dev, rd};
    endfunction

endpackage

// File: rtl/eei2c_qtick.sv
module eei2c_qtick #(
    parameter int QDIV = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/eei2c_bitphy.sv
module eei2c_bitphy
    import eei2c_pkg::*;
#(
    parameter int QDIV = 250
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   go,
    input  bitop_e op,
    input  logic   wbit,
    input  logic   scl_i,
    input  logic   sda_i,
    output logic   op_done,
    output logic   rbit,
    output logic   scl_oe,
    output logic   sda_oe
);
    logic       active;
    logic [1:0] ph;
    bitop_e     cur;
    logic       wb;
    pins_s      pins;
    logic       tick;
    logic       held;

    // Phase 1 releases SCL; wait there while a slave keeps it low.
    assign held = active && (ph == 2'd1) && !scl_i;

    eei2c_qtick #(.QDIV(QDIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .clr (go && !active),
        .en  (active && !held),
        .tick(tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            ph      <= 2'd0;
            cur     <= OP_STOP;
            wb      <= 1'b1;
            pins    <= '0;
            op_done <= 1'b0;
            rbit    <= 1'b1;
        end else begin
            op_done <= 1'b0;
            if (!active && go) begin
                active <= 1'b1;
                ph     <= 2'd0;
                cur    <= op;
                wb     <= wbit;
                pins   <= phase_pins(op, 2'd0, wbit, pins.scl_low);
            end else if (tick) begin
                if (ph == 2'd2) rbit <= sda_i;
                if (ph == 2'd3) begin
                    active  <= 1'b0;
                    op_done <= 1'b1;
                end else begin
                    ph   <= ph + 2'd1;
                    pins <= phase_pins(cur, ph + 2'd1, wb, pins.scl_low);
                end
            end
        end
    end

    assign scl_oe = pins.scl_low;
    assign sda_oe = pins.sda_low;
endmodule

// File: rtl/eeprom_i2c_master.sv
module eeprom_i2c_master
    import eei2c_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int SCL_HZ = 100_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [6:0]  cmd_dev,
    input  logic        cmd_rd,
    input  logic [15:0] cmd_mem,
    input  logic [7:0]  cmd_wdata,
    output logic        busy,
    output logic        done,
    output logic        ack_err,
    output logic [7:0]  rdata,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic        scl_i,
    input  logic        sda_i
);
    localparam int QDIV = CLK_HZ / (4 * SCL_HZ);

    seq_e       st;
    xfer_s      xf;
    logic       go;
    bitop_e     op;
    logic       wbit;
    logic [3:0] bitn;
    logic [1:0] bidx;
    logic [7:0] sh;
    logic [7:0] next_byte;
    logic       err;
    logic       op_done;
    logic       rbit;

    eei2c_bitphy #(.QDIV(QDIV)) u_phy (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .op     (op),
        .wbit   (wbit),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .op_done(op_done),
        .rbit   (rbit),
        .scl_oe (scl_oe),
        .sda_oe (sda_oe)
    );

    always_comb begin
        case (bidx)
            2'd0:    next_byte = xf.mem[15:8];
            2'd1:    next_byte = xf.mem[7:0];
            default: next_byte = xf.wdata;
        endcase
    end

    assign busy = (st != SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            xf      <= '0;
            go      <= 1'b0;
            op      <= OP_STOP;
            wbit    <= 1'b1;
            bitn    <= 4'd0;
            bidx    <= 2'd0;
            sh      <= 8'd0;
            err     <= 1'b0;
            done    <= 1'b0;
            ack_err <= 1'b0;
            rdata   <= 8'd0;
        end else begin
            go   <= 1'b0;
            done <= 1'b0;
            case (st)
                SQ_IDLE: if (cmd_valid) begin
                    xf      <= '{dev: cmd_dev, rd: cmd_rd, mem: cmd_mem, wdata: cmd_wdata};
                    err     <= 1'b0;
                    ack_err <= 1'b0;
                    bidx    <= 2'd0;
                    st      <= SQ_START;
                    go      <= 1'b1;
                    op      <= OP_START;
                end
                SQ_START, SQ_RSTART: if (op_done) begin
                    sh   <= addr_byte(xf.dev, st == SQ_RSTART);
                    bidx <= (st == SQ_RSTART) ? 2'd3 : 2'd0;
                    bitn <= 4'd0;
                    st   <= SQ_TX;
                    go   <= 1'b1;
                    op   <= OP_WRITE;
                    wbit <= xf.dev[6];
                end
                SQ_TX: if (op_done) begin
                    go <= 1'b1;
                    if (bitn < 4'd7) begin
                        bitn <= bitn + 4'd1;
                        sh   <= {sh[6:0], 1'b0};
                        op   <= OP_WRITE;
                        wbit <= sh[6];
                    end else if (bitn == 4'd7) begin
                        bitn <= 4'd8;
                        op   <= OP_READ;
                    end else if (rbit) begin
                        err <= 1'b1;
                        st  <= SQ_STOP;
                        op  <= OP_STOP;
                    end else begin
                        bitn <= 4'd0;
                        if (bidx == 2'd3) begin
                            st <= xf.rd ? SQ_RX : SQ_STOP;
                            op <= xf.rd ? OP_READ : OP_STOP;
                        end else if (bidx == 2'd2 && xf.rd) begin
                            st <= SQ_RSTART;
                            op <= OP_START;
                        end else begin
                            sh   <= next_byte;
                            bidx <= bidx + 2'd1;
                            op   <= OP_WRITE;
                            wbit <= next_byte[7];
                        end
                    end
                end
                SQ_RX: if (op_done) begin
                    sh <= {sh[6:0], rbit};
                    go <= 1'b1;
                    if (bitn == 4'd7) begin
                        rdata <= {sh[6:0], rbit};
                        st    <= SQ_NACK;
                        op    <= OP_WRITE;
                        wbit  <= 1'b1;
                    end else begin
                        bitn <= bitn + 4'd1;
                        op   <= OP_READ;
                    end
                end
                SQ_NACK: if (op_done) begin
                    st <= SQ_STOP;
                    go <= 1'b1;
                    op <= OP_STOP;
                end
                SQ_STOP: if (op_done) begin
                    st      <= SQ_IDLE;
                    done    <= 1'b1;
                    ack_err <= err;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eei2c_checker.sv
module eei2c_checker (
    input logic clk,
    input logic rst,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic ack_err,
    input logic scl_oe,
    input logic sda_oe,
    input logic scl_i
);
    logic rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d && !rst) begin
            AST_RESET_QUIET: assert (!busy && !done && !ack_err && !scl_oe && !sda_oe); // R1
        end
    end

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst) (!busy && cmd_valid) |=> busy); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R8
    AST_LINES_FREE: assert property (@(posedge clk) disable iff (rst) done |-> (!scl_oe && !sda_oe)); // R2
    AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (rst) $rose(ack_err) |-> done); // R4
    AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (rst) (busy && !scl_oe && !scl_i) |=> !scl_oe); // R9
endmodule

bind eeprom_i2c_master eei2c_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .busy     (busy),
    .done     (done),
    .ack_err  (ack_err),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .scl_i    (scl_i)
);

// File: tb/sim_eeprom_i2c_master.sv
`timescale 1ns/1ps
module sim_eeprom_i2c_master;
    localparam int CLK_HZ = 2_000_000;
    localparam int SCL_HZ = 100_000;
    localparam int Q      = CLK_HZ / (4 * SCL_HZ);
    localparam int EV_S = 256, EV_P = 257, EV_MACK = 258, EV_MNACK = 259;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [6:0] cmd_dev = '0;
    logic cmd_rd = 1'b0;
    logic [15:0] cmd_mem = '0;
    logic [7:0] cmd_wdata = '0;
    logic busy, done, ack_err, scl_oe, sda_oe;
    logic [7:0] rdata;
    logic slv_scl_low = 1'b0;
    logic slv_sda_low = 1'b0;
    wire scl = !(scl_oe || slv_scl_low);
    wire sda = !(sda_oe || slv_sda_low);

    always #5 clk = ~clk;

    eeprom_i2c_master #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_dev(cmd_dev),
        .cmd_rd(cmd_rd), .cmd_mem(cmd_mem), .cmd_wdata(cmd_wdata),
        .busy(busy), .done(done), .ack_err(ack_err), .rdata(rdata),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_i(scl), .sda_i(sda)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural slave model and bus monitor, evaluated on falling clock.
    int ev[$];
    int nack_at = 99;
    logic [7:0] txb = 8'h00;
    int stretch_idx = -1;
    int stretch_len = 0;
    bit chk_hi = 1'b0;
    int mode = 0;       // 0 idle, 1 slave receiving, 2 slave sending
    int bitc = 0;
    int rxn = 0;
    int hi = 0;
    int st_cnt = 0;
    bit fresh = 1'b0;
    bit first = 1'b0;
    bit last_ack = 1'b0;
    logic [7:0] srx = 8'h00;
    logic p_scl = 1'b1;
    logic p_sda = 1'b1;

    always @(negedge clk) begin
        logic s, d;
        s = scl;
        d = sda;
        cyc++;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
        if (rst) begin
            mode = 0; rxn = 0; hi = 0; slv_sda_low = 1'b0; slv_scl_low = 1'b0;
        end else begin
            if (st_cnt > 0) begin
                st_cnt--;
                if (st_cnt == 0) slv_scl_low = 1'b0;
            end
            if (s && p_scl && p_sda && !d) begin
                ev.push_back(EV_S);
                mode = 1; bitc = 0; fresh = 1'b1; first = 1'b1; slv_sda_low = 1'b0;
            end else if (s && p_scl && !p_sda && d) begin
                ev.push_back(EV_P);
                mode = 0; rxn = 0; slv_sda_low = 1'b0;
            end else if (s && !p_scl) begin
                if (mode == 1 && bitc < 8) srx = {srx[6:0], d};
                else if (mode == 2 && bitc == 8) ev.push_back(d ? EV_MNACK : EV_MACK);
            end else if (!s && p_scl) begin
                if (chk_hi && mode != 0 && !fresh)
                    chk(hi == 2 * Q, "R6", "SCL high cycles", hi, 2 * Q);
                if (fresh) begin
                    fresh = 1'b0;
                end else if (mode != 0) begin
                    if (bitc < 8) begin
                        bitc++;
                        if (bitc == 8) begin
                            if (mode == 1) begin
                                ev.push_back(int'(srx));
                                last_ack = (rxn != nack_at);
                                slv_sda_low = last_ack;
                                rxn++;
                            end else begin
                                slv_sda_low = 1'b0;
                            end
                        end else if (mode == 2) begin
                            slv_sda_low = !txb[7 - bitc];
                        end
                    end else begin
                        bitc = 0;
                        if (mode == 1) begin
                            if (stretch_idx == rxn - 1 && last_ack) begin
                                slv_scl_low = 1'b1;
                                st_cnt = stretch_len;
                            end
                            if (first && srx[0] && last_ack) begin
                                mode = 2;
                                slv_sda_low = !txb[7];
                            end else begin
                                slv_sda_low = 1'b0;
                                if (!last_ack) mode = 0;
                            end
                        end else begin
                            mode = 0;
                            slv_sda_low = 1'b0;
                        end
                        first = 1'b0;
                    end
                end
            end
            hi = s ? hi + 1 : 0;
        end
        p_scl = s;
        p_sda = d;
    end

    logic [7:0] exp_rdata = 8'h00;

    task automatic do_xfer(input logic [6:0] dev, input logic rd, input logic [15:0] mem,
                           input logic [7:0] wd, input int nidx, input logic [7:0] tv,
                           input int sidx, input int slen, input bit poke, input string req);
        int exp_ev[$];
        int sent[4];
        bit ok;
        int n;
        bit fail_ack;
        sent[0] = int'({dev, 1'b0});
        sent[1] = int'(mem[15:8]);
        sent[2] = int'(mem[7:0]);
        sent[3] = rd ? int'({dev, 1'b1}) : int'(wd);
        fail_ack = (nidx < 4);
        exp_ev.push_back(EV_S);
        for (int i = 0; i < 4; i++) begin
            if (rd && i == 3) exp_ev.push_back(EV_S);
            exp_ev.push_back(sent[i]);
            if (i == nidx) break;
        end
        if (rd && !fail_ack) exp_ev.push_back(EV_MNACK);
        exp_ev.push_back(EV_P);
        if (rd && !fail_ack) exp_rdata = tv;

        nack_at = nidx; txb = tv; stretch_idx = sidx; stretch_len = slen;
        chk_hi = (sidx < 0);
        ev.delete();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_dev = dev; cmd_rd = rd; cmd_mem = mem; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R7", "busy after accept", int'(busy), 1);
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
            if (poke && n == 30) begin
                cmd_valid = 1'b1; cmd_dev = 7'h11; cmd_rd = 1'b0; cmd_wdata = 8'h66;
            end
            if (poke && n == 33) cmd_valid = 1'b0;
            if (!done && !busy) chk(1'b0, "R8", "busy dropped before done", 0, 1);
        end
        chk(done == 1'b1, "R8", "done seen", int'(done), 1);
        chk(busy == 1'b0, "R8", "busy in done cycle", int'(busy), 0);
        chk(ack_err == fail_ack, fail_ack ? "R4" : (rd ? "R3" : "R2"), "ack_err",
            int'(ack_err), int'(fail_ack));
        chk(ev.size() == exp_ev.size(), req, "bus event count (R5)", ev.size(), exp_ev.size());
        ok = (ev.size() == exp_ev.size());
        for (int i = 0; i < exp_ev.size() && ok; i++) begin
            if (ev[i] != exp_ev[i]) begin
                chk(1'b0, req, $sformatf("bus event %0d (R5)", i), ev[i], exp_ev[i]);
                ok = 1'b0;
            end
        end
        chk(rdata == exp_rdata, fail_ack ? "R4" : "R3", "rdata", int'(rdata), int'(exp_rdata));
        @(negedge clk);
        chk(done == 1'b0, "R8", "done width", int'(done), 0);
        chk(ack_err == fail_ack, "R4", "ack_err held", int'(ack_err), int'(fail_ack));
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && !scl_oe && !sda_oe, "R7", "idle after done, no queued command",
            int'(busy), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        chk(done == 1'b0 && ack_err == 1'b0, "R1", "done/ack_err in reset",
            int'(done) + int'(ack_err), 0);
        chk(!scl_oe && !sda_oe, "R1", "lines released in reset",
            int'(scl_oe) + int'(sda_oe), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        // R2: plain write, timing checked (R6)
        do_xfer(7'h50, 1'b0, 16'h1234, 8'hA5, 99, 8'h00, -1, 0, 1'b0, "R2");
        // R3: reads with two data patterns
        do_xfer(7'h50, 1'b1, 16'hBEEF, 8'h00, 99, 8'h3C, -1, 0, 1'b0, "R3");
        do_xfer(7'h2B, 1'b1, 16'h0001, 8'h00, 99, 8'hC3, -1, 0, 1'b0, "R3");
        // R4: missing acknowledge at several bytes
        do_xfer(7'h50, 1'b0, 16'h4321, 8'h77, 0, 8'h00, -1, 0, 1'b0, "R4");
        do_xfer(7'h50, 1'b0, 16'h4321, 8'h77, 2, 8'h00, -1, 0, 1'b0, "R4");
        do_xfer(7'h50, 1'b1, 16'h8000, 8'h00, 1, 8'h5A, -1, 0, 1'b0, "R4");
        do_xfer(7'h50, 1'b1, 16'h8000, 8'h00, 3, 8'h5A, -1, 0, 1'b0, "R4");
        // R7: command pulsed while busy is ignored; R4 error cleared by this success
        do_xfer(7'h7F, 1'b0, 16'hFFFF, 8'h00, 99, 8'h00, -1, 0, 1'b1, "R7");
        // R9: short clock hold after the high address byte
        do_xfer(7'h50, 1'b0, 16'h0F0F, 8'h81, 99, 8'h00, 1, 40, 1'b0, "R9");
        // R10: long hold before the data byte of a read
        do_xfer(7'h3A, 1'b1, 16'hA55A, 8'h00, 99, 8'h96, 3, 3000, 1'b0, "R10");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule